// File: doc/BRIEF.md
# Interleaved Flash Prefetch Controller

This block connects a CPU instruction-fetch port to a flash model built from two banks. Each bank returns 128 bits per access. The flash is split into 32-byte lines. The lower 16 bytes of a line live in bank 0 and the upper 16 bytes in bank 1. On a miss, the controller reads both banks of the line in the same access and places the 256 bits in a single prefetch line. Any 32-bit word inside that line is then returned in the same cycle it is requested.

A fetch outside the buffered line stalls the requester. The stall length comes from a wait-state input, which is set from the CPU clock frequency (0 to 4 in practice). The controller also takes a one-cycle sector-erase command. Each erase sets the same sector in both banks to all ones at once, and it drops the prefetch line if that line lies in the erased range.

With the default parameters the flash holds 64 lines (2 KB). An erase sector covers 16 lines, which is 256 bytes per bank and 512 bytes in total. After reset the flash holds a fixed image derived from the address, so the contents are known without any programming path.

Top module: `flash_prefetch_ctrl`

## Requirements
- R1: After reset the prefetch line is invalid, so the first fetch takes the miss path. `req_ready` is never high while `req_valid` is low.
- R2: Byte address bit 4 selects the bank: offsets 0x00–0x0F of a line come from bank 0 and 0x10–0x1F from bank 1. Bits 3:2 pick the word within the bank half. Bits 10:5 give the line index. Bits 31:11 and 1:0 are ignored, so addresses alias every 2 KB.
- R3: After reset, the word at byte address A holds {16'hC0DE ^ n, n}, where n is A[10:2] zero-extended to 16 bits.
- R4: A fetch whose line is buffered gets `req_ready` high in the same cycle, with the addressed word on `rd_data`.
- R5: A fetch whose line is not buffered keeps `req_ready` low. `req_ready` first goes high ws+1 cycles after the first request cycle, where ws is `wait_states` as sampled in that first cycle. Later changes to `wait_states` during the stall have no effect.
- R6: One miss loads all eight words of the line, so every other word of that line then hits with no stall.
- R7: Only one line is buffered. Fetching a different line evicts it, and a later return to the old line misses again.
- R8: A one-cycle `erase_valid` with sector s sets lines s·16 to s·16+15 to all ones in both banks. Other sectors are unchanged.
- R9: An erase invalidates the prefetch line only if that line lies in the erased sector. Otherwise the buffered line still hits with its old data.
- R10: While `req_ready` stays high with the same address and no erase occurs, `rd_data` is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request, held until ready |
| req_addr | input | 32 | Byte address of the requested word |
| req_ready | output | 1 | Word on rd_data is valid this cycle |
| rd_data | output | 32 | Fetched word |
| wait_states | input | 3 | Miss wait states, sampled at miss start |
| erase_valid | input | 1 | One-cycle sector-erase command |
| erase_sector | input | 2 | Index of the sector pair to erase |

## Verification
The test walks all eight words of a line, which exercises both bank halves and confirms a single miss fills 256 bits. A miss is then run at each wait-state value from 0 to 4, with the value changed partway through one stall, which separates a latency that is sampled once from one that tracks the input. Fetches alternate between two lines and also use an aliased address, which shows there is only one buffered line and which address bits are ignored. Erases are issued both into the buffered line's sector and away from it, with the erased words read back from both banks and from the first line of the next sector. This distinguishes correct invalidation from too much or too little invalidation, and correct erase bounds from erasing the wrong range.

// File: rtl/flash_prefetch_ctrl.sv
module flash_prefetch_ctrl #(
  parameter int LINES = 64,
  parameter int SECTOR_LINES = 16,
  localparam int LINE_W = $clog2(LINES),
  localparam int SEC_SH = $clog2(SECTOR_LINES),
  localparam int SEC_W = LINE_W - SEC_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              req_ready,
  output logic [31:0]       rd_data,
  input  logic [2:0]        wait_states,
  input  logic              erase_valid,
  input  logic [SEC_W-1:0]  erase_sector
);

  logic [127:0] bank0 [LINES];
  logic [127:0] bank1 [LINES];

  logic              buf_valid;
  logic [LINE_W-1:0] buf_line;
  logic [255:0]      buf_data;
  logic              busy;
  logic [2:0]        cnt;
  logic [LINE_W-1:0] miss_line;

  function automatic logic [127:0] image_half(input int ln, input int bk);
    logic [127:0] h;
    logic [15:0]  n;
    for (int w = 0; w < 4; w++) begin
      n = 16'(ln * 8 + bk * 4 + w);
      h[w*32 +: 32] = {16'hC0DE ^ n, n};
    end
    return h;
  endfunction

  function automatic logic in_sector(input logic [LINE_W-1:0] ln, input logic [SEC_W-1:0] s);
    return ln[LINE_W-1:SEC_SH] == s;
  endfunction

  wire [LINE_W-1:0] req_line = req_addr[LINE_W+4:5];
  wire hit   = buf_valid && (buf_line == req_line);
  wire start = !busy && req_valid && !hit && (wait_states != 3'd0);
  wire fill  = busy ? (cnt == 3'd0) : (req_valid && !hit && (wait_states == 3'd0));
  wire [LINE_W-1:0] fill_line = busy ? miss_line : req_line;
  wire [LINE_W-1:0] next_line = fill ? fill_line : buf_line;
  wire unused_addr = ^{req_addr[31:LINE_W+5], req_addr[1:0]};

  assign req_ready = req_valid && hit && !busy;
  assign rd_data   = buf_data[{req_addr[4:2], 5'b0} +: 32];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) begin
        bank0[l] <= image_half(l, 0);
        bank1[l] <= image_half(l, 1);
      end
    end else if (erase_valid) begin
      for (int l = 0; l < LINES; l++) begin
        if (in_sector(LINE_W'(l), erase_sector)) begin
          bank0[l] <= '1;
          bank1[l] <= '1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_line  <= '0;
      buf_data  <= '0;
      busy      <= 1'b0;
      cnt       <= '0;
      miss_line <= '0;
    end else begin
      if (start) begin
        busy      <= 1'b1;
        cnt       <= wait_states - 3'd1;
        miss_line <= req_line;
      end else if (busy && cnt != 3'd0) begin
        cnt <= cnt - 3'd1;
      end
      if (fill) begin
        busy      <= 1'b0;
        buf_valid <= 1'b1;
        buf_line  <= fill_line;
        buf_data  <= {bank1[fill_line], bank0[fill_line]};
      end
      if (erase_valid && in_sector(next_line, erase_sector))
        buf_valid <= 1'b0;
    end
  end

endmodule

module flash_prefetch_chk #(
  parameter int LINE_W = 6,
  parameter int SEC_SH = 4,
  parameter int SEC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [31:0]      req_addr,
  input logic             req_ready,
  input logic [31:0]      rd_data,
  input logic [2:0]       wait_states,
  input logic             erase_valid,
  input logic [SEC_W-1:0] erase_sector,
  input logic             busy
);

  wire unused_chk = ^{req_addr[31:LINE_W+5], req_addr[SEC_SH+4:0]};

  // R1
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  // R5
  stall_holds_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R5
  zero_wait_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !req_ready && wait_states == 3'd0 && !erase_valid)
    ##1 (req_valid && $stable(req_addr)) |-> req_ready);

  // R8
  erased_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(erase_valid) && req_ready &&
     req_addr[LINE_W+4:SEC_SH+5] == $past(erase_sector)) |-> (rd_data == 32'hFFFF_FFFF));

  // R10
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(req_ready) && $stable(req_addr) && !$past(erase_valid))
    |-> $stable(rd_data));

endmodule

bind flash_prefetch_ctrl flash_prefetch_chk #(
  .LINE_W(LINE_W), .SEC_SH(SEC_SH), .SEC_W(SEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_ready(req_ready), .rd_data(rd_data), .wait_states(wait_states),
  .erase_valid(erase_valid), .erase_sector(erase_sector), .busy(busy)
);

// File: tb/sim_flash_prefetch_ctrl.sv
module sim_flash_prefetch_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic [31:0] rd_data;
  logic [2:0]  wait_states = 3'd0;
  logic        erase_valid = 1'b0;
  logic [1:0]  erase_sector = '0;

  int checks = 0;
  int errors = 0;
  logic erased [4];
  bit done = 0;

  always #5 clk = ~clk;

  flash_prefetch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rd_data(rd_data), .wait_states(wait_states),
    .erase_valid(erase_valid), .erase_sector(erase_sector)
  );

  function automatic logic [31:0] expect_word(input logic [31:0] a);
    logic [15:0] n;
    n = {7'b0, a[10:2]};
    if (erased[a[10:9]]) return 32'hFFFF_FFFF;
    return {16'hC0DE ^ n, n};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a, input int lat_exp, input string req);
    int lat = 0;
    req_valid = 1'b1;
    req_addr  = a;
    forever begin
      #1;
      if (req_ready || lat > 20) break;
      @(negedge clk);
      lat++;
    end
    check(lat == lat_exp, {req, " latency"}, 32'(lat), 32'(lat_exp));
    check(rd_data == expect_word(a), {req, " data"}, rd_data, expect_word(a));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic erase(input logic [1:0] s);
    erase_valid  = 1'b1;
    erase_sector = s;
    @(negedge clk);
    erase_valid = 1'b0;
    erased[s] = 1'b1;
  endtask

  task automatic t_reset;
    #1;
    check(req_ready == 1'b0, "R1 idle ready", 32'(req_ready), 32'd0);
    wait_states = 3'd2;
    fetch(32'h40, 3, "R1 first fetch miss");
  endtask

  task automatic t_line_hits;
    for (int w = 0; w < 8; w++)
      fetch(32'h40 + 32'(w * 4), 0, w < 4 ? "R4 R6 R2 R3 bank0 hit" : "R4 R6 R2 R3 bank1 hit");
  endtask

  task automatic t_wait_states;
    int lat = 0;
    for (int w = 0; w < 5; w++) begin
      wait_states = 3'(w);
      fetch(32'h100 + 32'(w * 32) + 32'h14, w + 1, "R5 wait states");
    end
    wait_states = 3'd1;
    req_valid = 1'b1;
    req_addr  = 32'h208;
    forever begin
      #1;
      if (req_ready || lat > 20) break;
      @(negedge clk);
      lat++;
      wait_states = 3'd4;
    end
    check(lat == 2, "R5 sampled once", 32'(lat), 32'd2);
    check(rd_data == expect_word(32'h208), "R5 sampled data", rd_data, expect_word(32'h208));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_single_line;
    wait_states = 3'd0;
    fetch(32'h0C0, 1, "R7 line X");
    fetch(32'h2E4, 1, "R7 line Y");
    fetch(32'h0C4, 1, "R7 return to X misses");
    fetch(32'h4000_08D8, 0, "R2 alias hit");
  endtask

  task automatic t_erase;
    wait_states = 3'd0;
    fetch(32'h240, 1, "R9 buffer sector 1 line");
    erase(2'd0);
    fetch(32'h244, 0, "R9 other sector kept");
    fetch(32'h010, 1, "R8 erased bank1 word");
    fetch(32'h004, 0, "R8 erased bank0 word");
    fetch(32'h1FC, 1, "R8 erased last line");
    fetch(32'h240, 1, "R9 rebuffer");
    erase(2'd1);
    fetch(32'h248, 1, "R9 invalidated after erase");
    fetch(32'h3F0, 1, "R8 sector 1 end");
    fetch(32'h400, 1, "R8 next sector intact");
  endtask

  task automatic t_stable;
    logic [31:0] first;
    req_valid = 1'b1;
    req_addr  = 32'h404;
    #1;
    first = rd_data;
    check(req_ready == 1'b1, "R10 hit", 32'(req_ready), 32'd1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      check(req_ready == 1'b1 && rd_data == first, "R10 stable", rd_data, first);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    for (int s = 0; s < 4; s++) erased[s] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_line_hits;
    t_wait_states;
    t_single_line;
    t_erase;
    t_stable;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule